// File: doc/BRIEF.md
# Static Memory Timing Sequencer

This block turns single read or write requests from an internal valid/ready port into the pin-level cycle sequence that an asynchronous static memory expects. The memory can be an SRAM, a ROM, an asynchronous NOR device, or a NOR device with a shared address/data bus. Every access walks through an address setup phase, an optional address hold phase and a data phase. The length of each phase comes from its own timing field. The fields arrive as static inputs. The logic that holds them resets them to their maximum values (setup 15, hold 15, data 255).

The memory can stretch the data phase by holding an active-low wait line. That line is first passed through a two-stage synchronizer. When an access completes, a one-cycle acknowledge is returned, and for a read it carries the captured data. Chip select is released for exactly one cycle between back-to-back accesses.

Top module: `smem_seq`

## Requirements
- R1: After a request is accepted, the setup phase lasts `cfg_setup`+1 cycles (0 gives 1, 15 gives 16). Chip select is low throughout the setup phase, and output enable and write enable are high.
- R2: The hold phase follows setup only when `cfg_mode` is 01 (extended), 10 or 11 (multiplexed). Mode 00 (basic) goes straight from setup to data. The hold phase lasts `cfg_hold`+1 cycles, and a field value of 0 behaves as 1 (2 cycles).
- R3: Outside basic-mode reads, the data phase lasts `cfg_data`+1 cycles (255 gives 256), and a field value of 0 behaves as 1 (2 cycles).
- R4: A basic-mode (00) read has a data phase of `cfg_data`+3 cycles, with 0 treated as 1 (4 cycles).
- R5: `mem_oe_n` is low only during the data phase of a read. `mem_we_n` is low only during the data phase of a write. Neither is ever low while chip select is high.
- R6: In multiplexed modes, `mem_adv_n` is low during the setup phase only, and `mem_ad_oe` drives the low `DATA_W` bits of the address during setup and hold. In every mode, the bus is released during a read data phase and carries the write data during a write data phase. In non-multiplexed modes `mem_adv_n` stays high and the bus is driven only during a write data phase.
- R7: `mem_wait_n` low is seen through a two-flop synchronizer. From the third data-phase cycle onward, a synchronized wait freezes the data phase for that cycle. A wait during the first two data cycles has no effect on timing.
- R8: Read data is taken from `mem_ad_in` at the clock edge that ends the last data cycle. `rsp_valid` pulses for one cycle right after every access, and `rsp_rdata` holds the read value.
- R9: `req_ready` is high only while no access is in progress, and a request is accepted on `req_valid && req_ready`. Between back-to-back accesses, chip select is high for exactly one cycle, which is the acknowledge cycle.
- R10: Under reset, the outputs are idle: chip select, output enable, write enable and address-valid are high, the bus is not driven, `rsp_valid` is 0 and `req_ready` is 1.
- R11: While chip select is low, `mem_addr` carries the address of the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Access mode: 00 basic, 01 extended, 10/11 multiplexed |
| cfg_setup | input | 4 | Address setup field |
| cfg_hold | input | 4 | Address hold field |
| cfg_data | input | 8 | Data phase field |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle access completion |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | ADDR_W | Address pins |
| mem_ad_out | output | DATA_W | Address/data bus output value |
| mem_ad_oe | output | 1 | Address/data bus output enable |
| mem_ad_in | input | DATA_W | Address/data bus input value |
| mem_wait_n | input | 1 | Memory wait, active low, asynchronous |

## Verification
The bench runs reads and writes in all four mode codes. Each mode code settles whether the hold phase appears and whether the basic-read data extension applies. The field values include 0 in every field, so the reserved encodings show apart from the plain off-by-one rule, and the maximum settings of setup 15, hold 15 and data 255 prove that the counters do not wrap. Wait pulses are placed in two ways: one only reaches the first two data cycles and must change nothing, the other lands later and must stretch the phase by the same number of cycles. A changing pattern on the bus input pins the read capture to the last data cycle. Back-to-back requests confirm the single-cycle gap in chip select.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int SETUP_FW = 4;
    localparam int HOLD_FW  = 4;
    localparam int DATA_FW  = 8;
    localparam int CNT_W    = DATA_FW + 1;   // room for basic-read extension

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        MODE_BASIC = 2'b00,
        MODE_EXT   = 2'b01,
        MODE_MUX   = 2'b10,
        MODE_MUX2  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_SETUP = 2'b01,
        PH_HOLD  = 2'b10,
        PH_DATA  = 2'b11
    } phase_e;

    typedef struct packed {
        logic [SETUP_FW-1:0] setup;
        logic [HOLD_FW-1:0]  hold;
        logic [DATA_FW-1:0]  data;
    } timing_t;

    function automatic logic is_mux(mode_e m);
        return m[1];
    endfunction

    function automatic logic uses_hold(mode_e m);
        return m != MODE_BASIC;
    endfunction

    // Counter loads are "cycles - 1"; the phase ends when the counter is zero.
    function automatic cnt_t setup_load(timing_t t);
        return cnt_t'(t.setup);
    endfunction

    function automatic cnt_t hold_load(timing_t t);
        return (t.hold == '0) ? cnt_t'(1) : cnt_t'(t.hold);
    endfunction

    function automatic cnt_t data_load(timing_t t, logic basic_read);
        cnt_t d;
        d = (t.data == '0) ? cnt_t'(1) : cnt_t'(t.data);
        return basic_read ? d + cnt_t'(2) : d;
    endfunction

endpackage

// File: rtl/smem_wait_sync.sv
module smem_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wait_n_async,
    output logic wait_sync
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], ~wait_n_async};
    end

    assign wait_sync = sr[STAGES-1];
endmodule

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
    import smem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    write_i,
    input  mode_e   mode_i,
    input  timing_t timing_i,
    input  logic    wait_i,
    output phase_e  phase_o,
    output logic    write_o,
    output mode_e   mode_o,
    output logic    last_o
);
    localparam logic [1:0] WAIT_GRACE = 2'd2;

    phase_e     phase;
    cnt_t       cnt;
    logic [1:0] dcyc;
    logic       write_q;
    mode_e      mode_q;
    logic       stall;
    logic       read_basic;

    assign read_basic = !write_q && (mode_q == MODE_BASIC);
    assign stall      = (phase == PH_DATA) && (dcyc == WAIT_GRACE) && wait_i;
    assign last_o     = (phase == PH_DATA) && (cnt == '0) && !stall;
    assign phase_o    = phase;
    assign write_o    = write_q;
    assign mode_o     = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            dcyc    <= '0;
            write_q <= 1'b0;
            mode_q  <= MODE_BASIC;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_SETUP;
                        cnt     <= setup_load(timing_i);
                        write_q <= write_i;
                        mode_q  <= mode_i;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        if (uses_hold(mode_q)) begin
                            phase <= PH_HOLD;
                            cnt   <= hold_load(timing_i);
                        end else begin
                            phase <= PH_DATA;
                            cnt   <= data_load(timing_i, read_basic);
                            dcyc  <= '0;
                        end
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_DATA;
                        cnt   <= data_load(timing_i, read_basic);
                        dcyc  <= '0;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                default: begin
                    if (!stall) begin
                        if (cnt == '0) begin
                            phase <= PH_IDLE;
                        end else begin
                            cnt <= cnt - cnt_t'(1);
                            if (dcyc != WAIT_GRACE) dcyc <= dcyc + 2'd1;
                        end
                    end
                end
            endcase
        end
    end

    // R1: an accepted request always opens with the setup phase
    a_r1_start_setup: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == PH_SETUP));

    // R2: basic mode never enters the hold phase
    a_r2_basic_skips_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETUP && cnt == '0 && mode_q == MODE_BASIC) |=> (phase == PH_DATA));

    // R7: a synchronized wait after the grace cycles freezes the data phase
    a_r7_stall_freezes: assert property (@(posedge clk) disable iff (rst)
        stall |=> (phase == PH_DATA && $stable(cnt)));

    // R7: during the first two data cycles the count always advances
    a_r7_grace_ignores_wait: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && dcyc != WAIT_GRACE && cnt != '0) |=> (cnt == cnt_t'($past(cnt) - cnt_t'(1))));

    // R9: the end of the data phase returns to idle for one turnaround cycle
    a_r9_end_to_idle: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (phase == PH_IDLE));

endmodule

// File: rtl/smem_pin_drive.sv
module smem_pin_drive
    import smem_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              write,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              adv_n,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic [ADDR_W-1:0] mem_addr
);
    logic in_access;
    logic addr_on_bus;
    logic data_phase;

    assign in_access   = (phase != PH_IDLE);
    assign data_phase  = (phase == PH_DATA);
    assign addr_on_bus = is_mux(mode) && (phase == PH_SETUP || phase == PH_HOLD);

    assign cs_n     = !in_access;
    assign oe_n     = !(data_phase && !write);
    assign we_n     = !(data_phase && write);
    assign adv_n    = !(is_mux(mode) && phase == PH_SETUP);
    assign ad_oe    = addr_on_bus || (data_phase && write);
    assign ad_out   = addr_on_bus ? addr[DATA_W-1:0] : wdata;
    assign mem_addr = addr;

    // R5: read and write strobes never overlap
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    // R5: strobes only inside a chip-select window
    a_r5_strobe_in_access: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !we_n) |-> !cs_n);

    // R6: address-valid only while the address is driven on the bus
    a_r6_adv_drives_bus: assert property (@(posedge clk) disable iff (rst)
        !adv_n |-> (ad_oe && !cs_n));

endmodule

// File: rtl/smem_seq.sv
module smem_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_mode,
    input  logic [SETUP_FW-1:0] cfg_setup,
    input  logic [HOLD_FW-1:0]  cfg_hold,
    input  logic [DATA_FW-1:0]  cfg_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_cs_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_adv_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_ad_out,
    output logic                mem_ad_oe,
    input  logic [DATA_W-1:0]   mem_ad_in,
    input  logic                mem_wait_n
);
    timing_t           timing;
    phase_e            phase;
    logic              cur_write;
    mode_e             cur_mode;
    logic              last_cycle;
    logic              start;
    logic              wait_s;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign timing    = '{setup: cfg_setup, hold: cfg_hold, data: cfg_data};
    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    smem_wait_sync #(.STAGES(2)) u_wait_sync (
        .clk          (clk),
        .rst          (rst),
        .wait_n_async (mem_wait_n),
        .wait_sync    (wait_s)
    );

    smem_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .write_i  (req_write),
        .mode_i   (mode_e'(cfg_mode)),
        .timing_i (timing),
        .wait_i   (wait_s),
        .phase_o  (phase),
        .write_o  (cur_write),
        .mode_o   (cur_mode),
        .last_o   (last_cycle)
    );

    smem_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .write    (cur_write),
        .mode     (cur_mode),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .cs_n     (mem_cs_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .adv_n    (mem_adv_n),
        .ad_oe    (mem_ad_oe),
        .ad_out   (mem_ad_out),
        .mem_addr (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (start) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rsp_valid <= last_cycle;
            if (last_cycle && !cur_write) rsp_rdata <= mem_ad_in;
        end
    end

    // R8: completion is a single-cycle pulse
    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9: the acknowledge cycle is the chip-select gap
    a_r9_ack_gap: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_cs_n && req_ready));

    // R9: ready never coincides with an active access
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n);

endmodule

// File: tb/test_smem_seq.sv
module test_smem_seq;
    import smem_pkg::*;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = 2'b00;
    logic [3:0]    cfg_setup = 4'd15;
    logic [3:0]    cfg_hold = 4'd15;
    logic [7:0]    cfg_data = 8'd255;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_ad_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_ad_out;
    logic [DW-1:0] mem_ad_in = '0;
    logic          mem_wait_n = 1'b1;

    always #10 clk = ~clk;

    smem_seq #(.ADDR_W(AW), .DATA_W(DW)) i_smem_seq (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_setup(cfg_setup),
        .cfg_hold(cfg_hold), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_adv_n(mem_adv_n), .mem_addr(mem_addr), .mem_ad_out(mem_ad_out),
        .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in), .mem_wait_n(mem_wait_n)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    // Behavioural reference: phase number, cycles left, data cycles done
    int            m_ph = 0;       // 0 idle, 1 setup, 2 hold, 3 data
    int            m_left = 0;
    int            m_didx = 0;
    bit            m_wr = 0;
    int            m_mode = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [DW-1:0] m_rdata = '0;
    bit            m_ack = 0;
    bit            ws1 = 0, ws2 = 0;

    always @(posedge clk) begin
        bit stall, ack_n;
        int hh, dd;
        cyc++;
        if (rst) begin
            m_ph = 0; m_left = 0; m_didx = 0; m_ack = 0; ws1 = 0; ws2 = 0;
            m_rdata = '0; m_addr = '0; m_wdata = '0;
        end else begin
            stall = (m_ph == 3) && (m_didx >= 2) && ws2;
            ack_n = 0;
            hh = (cfg_hold == 0) ? 1 : int'(cfg_hold);
            dd = (cfg_data == 0) ? 1 : int'(cfg_data);
            if (m_mode == 0 && !m_wr) dd = dd + 3; else dd = dd + 1;
            case (m_ph)
                0: if (req_valid) begin
                    m_ph = 1; m_left = int'(cfg_setup) + 1;
                    m_wr = req_write; m_mode = int'(cfg_mode);
                    m_addr = req_addr; m_wdata = req_wdata;
                end
                1: if (m_left == 1) begin
                    if (m_mode != 0) begin m_ph = 2; m_left = hh + 1; end
                    else begin m_ph = 3; m_left = dd; m_didx = 0; end
                end else m_left--;
                2: if (m_left == 1) begin m_ph = 3; m_left = dd; m_didx = 0; end
                   else m_left--;
                default: if (!stall) begin
                    if (m_left == 1) begin
                        m_ph = 0; ack_n = 1;
                        if (!m_wr) m_rdata = mem_ad_in;
                    end else begin
                        m_left--; m_didx++;
                    end
                end
            endcase
            ws2 = ws1; ws1 = !mem_wait_n;
            m_ack = ack_n;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        string t;
        bit mux, exp_oe;
        if (!rst && cyc > 1) begin
            mux = (m_mode >= 2);
            case (m_ph)
                0: t = "R9";
                1: t = "R1";
                2: t = "R2";
                default: t = (m_didx >= 2 && ws2) ? "R7" : ((m_mode == 0 && !m_wr) ? "R4" : "R3");
            endcase
            chk(t, "cs_n", 32'(mem_cs_n), 32'(m_ph == 0));
            chk("R5", "oe_n", 32'(mem_oe_n), 32'(!(m_ph == 3 && !m_wr)));
            chk("R5", "we_n", 32'(mem_we_n), 32'(!(m_ph == 3 && m_wr)));
            chk("R6", "adv_n", 32'(mem_adv_n), 32'(!(mux && m_ph == 1)));
            exp_oe = (mux && (m_ph == 1 || m_ph == 2)) || (m_ph == 3 && m_wr);
            chk("R6", "ad_oe", 32'(mem_ad_oe), 32'(exp_oe));
            if (exp_oe)
                chk("R6", "ad_out", 32'(mem_ad_out),
                    32'((m_ph == 3) ? m_wdata : m_addr[DW-1:0]));
            if (m_ph != 0) chk("R11", "mem_addr", 32'(mem_addr), 32'(m_addr));
            chk("R9", "req_ready", 32'(req_ready), 32'(m_ph == 0));
            chk("R8", "rsp_valid", 32'(rsp_valid), 32'(m_ack));
            if (m_ack && !m_wr) chk("R8", "rsp_rdata", 32'(rsp_rdata), 32'(m_rdata));
        end
    end

    // Changing bus input so that the capture cycle is visible
    initial forever begin
        @(negedge clk);
        mem_ad_in = DW'(cyc * 37 + 5);
    end

    // Issue one access at a negedge in an idle cycle; return in its ack cycle.
    // Wait is driven low for access cycles k in [wlo, whi).
    task automatic run(input bit wr, input logic [1:0] mode, input logic [3:0] su,
                       input logic [3:0] ho, input logic [7:0] da,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input int wlo, input int whi);
        cfg_mode = mode; cfg_setup = su; cfg_hold = ho; cfg_data = da;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (m_ack) break;
            mem_wait_n = !(k >= wlo && k < whi);
            @(negedge clk);
        end
        mem_wait_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R9 watchdog: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: idle outputs under reset
        chk("R10", "cs_n", 32'(mem_cs_n), 32'(1));
        chk("R10", "oe_n", 32'(mem_oe_n), 32'(1));
        chk("R10", "we_n", 32'(mem_we_n), 32'(1));
        chk("R10", "adv_n", 32'(mem_adv_n), 32'(1));
        chk("R10", "ad_oe", 32'(mem_ad_oe), 32'(0));
        chk("R10", "rsp_valid", 32'(rsp_valid), 32'(0));
        chk("R10", "req_ready", 32'(req_ready), 32'(1));
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R4: basic read, field 1 -> 4 data cycles; setup 0 -> 1 cycle (R1)
        run(1'b0, 2'b00, 4'd0, 4'd7, 8'd1, 20'h1_2345, 16'h0, -1, -1);
        // R3: basic write with reserved data field 0 -> 2 cycles, setup 15
        run(1'b1, 2'b00, 4'd15, 4'd0, 8'd0, 20'h0_0abc, 16'hbeef, -1, -1);
        repeat (3) @(negedge clk);
        // R2: extended read, reserved hold 0 -> 2 cycles
        run(1'b0, 2'b01, 4'd2, 4'd0, 8'd5, 20'h5_5555, 16'h0, -1, -1);
        // R4: basic read with reserved data 0 -> 4 cycles
        run(1'b0, 2'b00, 4'd1, 4'd0, 8'd0, 20'h0_0010, 16'h0, -1, -1);
        // R6: multiplexed write, hold 3, data 2
        run(1'b1, 2'b10, 4'd1, 4'd3, 8'd2, 20'hf_1234, 16'h1357, -1, -1);
        // R7: wait only during first two data cycles, no effect
        run(1'b1, 2'b01, 4'd0, 4'd1, 8'd6, 20'h0_7777, 16'h2468, 1, 3);
        // R7: stall later in a multiplexed read
        run(1'b0, 2'b10, 4'd1, 4'd1, 8'd8, 20'ha_0f0f, 16'h0, 5, 10);
        // R7: stall in a basic read, long wait
        run(1'b0, 2'b00, 4'd3, 4'd2, 8'd4, 20'h3_3333, 16'h0, 6, 20);
        repeat (4) @(negedge clk);
        // R1/R2/R3: maximum fields (the reset defaults) in mode 11
        run(1'b0, 2'b11, 4'd15, 4'd15, 8'd255, 20'h9_8765, 16'h0, -1, -1);
        // R9: back-to-back writes and reads
        run(1'b1, 2'b00, 4'd0, 4'd0, 8'd1, 20'h0_0001, 16'h1111, -1, -1);
        run(1'b0, 2'b10, 4'd0, 4'd1, 8'd1, 20'h0_0002, 16'h0, -1, -1);
        run(1'b1, 2'b11, 4'd4, 4'd5, 8'd3, 20'h0_0003, 16'h3333, 8, 15);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule